// File: doc/BRIEF.md
# Parallel ATA Strobe Timing Generator

This block drives the read and write strobes of one parallel ATA channel for PIO and multiword DMA cycles. Each of the devices on the channel has its own 32-bit timing word. The word packs separate lengths for the setup, active and recovery phases of data-port transfers and of task-file register accesses. A request carries a device number, a direction and a class flag that tells a task-file access from a data transfer. The block sequences the phases, counting each one from its field, and pulses a done flag when the recovery phase ends.

The setup phase is inserted only when the bus has to settle. That happens on the first access after idle, or when the device, the direction or the class differs from the access just finished. A stream of like accesses that is accepted on each done pulse goes straight from recovery to the next strobe. A data request whose timing word selects Ultra DMA is refused: the strobes stay high and a flag reports the unsupported mode.

Top module: `ata_strobe_gen`

## Requirements
- R1: A synchronous reset, even in the middle of an access, forces both strobes high, drops done and unsupported, makes the block idle and ready, and clears every timing word to zero. With a zero word each phase lasts one clock.
- R2: On a data access the strobe is low for the value of word bits 7:4 plus one clocks. The recovery that follows lasts the value of bits 3:0 plus one clocks.
- R3: On a task-file access (class flag high) the strobe is low for the value of bits 15:12 plus one clocks. Recovery lasts the value of bits 11:8 plus one clocks.
- R4: When a setup phase is needed, it starts on the clock after acceptance with both strobes high. It lasts bits 21:19 plus one clocks for a data access and bits 24:22 plus one clocks for a task-file access. Setup is needed after idle, after a refused access, and whenever the device, the direction or the class differs from the previous access.
- R5: A request of the same device, direction and class that is accepted on the done clock drives its strobe low on the very next clock, with no setup.
- R6: Done is high for exactly one clock, the last recovery clock, unless it is immediately followed by another done. Ready is high when idle or on a done clock, and a request is taken on a rising edge where valid and ready are both high.
- R7: A read (direction 0) pulls only `dior_n` low and a write (direction 1) pulls only `diow_n` low. The two strobes are never low together.
- R8: The timing word used for an access is the one held for the device number given with the request. A word write with device number d changes only the word of device d.
- R9: A data access whose word has bit 28 set drives no strobe. On the clock after acceptance it shows done and unsupported together for one clock. A task-file access ignores bit 28.
- R10: A word write during an access leaves that access's phase lengths untouched. The new value applies from the next acceptance. A write on the same clock as an acceptance does not affect that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tw_wr_en | input | 1 | Write strobe for a timing word |
| tw_wr_dev | input | DEV_W | Device whose timing word is written |
| tw_wr_data | input | 32 | New timing word |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request this clock |
| req_dev | input | DEV_W | Target device of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data transfer |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| xfer_done | output | 1 | One-clock pulse at the end of recovery or on a refused access |
| unsup_mode | output | 1 | Pulse marking a refused Ultra DMA data access |

## Verification
The assertions assume that request fields and timing-word writes are steady around each rising edge. They also assume that the device number never names a device beyond the configured count. The bench changes inputs only on falling edges, restricts device numbers to the two present, and holds the request fields stable until acceptance. A behavioural reference with its own copy of both words predicts every output on every clock. It covers random words with bit 28 set about a quarter of the time, back-to-back streams that change kind mid-stream, word writes in mid-access, and a reset in the middle of an active strobe.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

   localparam int TW_W = 32;

   // timing word field positions (decoded by the sequencer)
   localparam int F_DREC_LSB  = 0;
   localparam int F_DACT_LSB  = 4;
   localparam int F_TREC_LSB  = 8;
   localparam int F_TACT_LSB  = 12;
   localparam int F_DSET_LSB  = 19;
   localparam int F_TSET_LSB  = 22;
   localparam int F_UDMA_BIT  = 28;
   localparam int LEN_W       = 4;
   localparam int SET_W       = 3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACTIVE,
      PH_RECOVER,
      PH_REJECT
   } phase_e;

   typedef struct packed {
      logic [LEN_W-1:0] act;
      logic [LEN_W-1:0] rec;
      logic [SET_W-1:0] setup;
   } phase_len_t;

   function automatic phase_len_t pick_lens(input logic [TW_W-1:0] w, input logic tf);
      phase_len_t l;
      if (tf) begin
         l.act   = w[F_TACT_LSB +: LEN_W];
         l.rec   = w[F_TREC_LSB +: LEN_W];
         l.setup = w[F_TSET_LSB +: SET_W];
      end else begin
         l.act   = w[F_DACT_LSB +: LEN_W];
         l.rec   = w[F_DREC_LSB +: LEN_W];
         l.setup = w[F_DSET_LSB +: SET_W];
      end
      return l;
   endfunction

endpackage

// File: rtl/ata_tword_bank.sv
module ata_tword_bank import ata_strobe_pkg::*; #(
   parameter int              NUM_DEV  = 2,
   parameter logic [TW_W-1:0] TW_RESET = '0,
   localparam int             DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en_i,
   input  logic [DEV_W-1:0] wr_dev_i,
   input  logic [TW_W-1:0]  wr_data_i,
   input  logic [DEV_W-1:0] rd_dev_i,
   output logic [TW_W-1:0]  rd_word_o
);

   logic [TW_W-1:0] regs [NUM_DEV];

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)
            regs[g] <= TW_RESET;
         else if (wr_en_i && (wr_dev_i == DEV_W'(g)))
            regs[g] <= wr_data_i;
      end

      // R8
      word_write_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en_i && wr_dev_i == DEV_W'(g)) |=> (regs[g] == $past(wr_data_i)));

      // R8
      word_keep_chk: assert property (@(posedge clk) disable iff (rst)
         (!wr_en_i || wr_dev_i != DEV_W'(g)) |=> $stable(regs[g]));
   end

   always_comb begin
      rd_word_o = '0;
      for (int i = 0; i < NUM_DEV; i++)
         if (rd_dev_i == DEV_W'(i))
            rd_word_o = regs[i];
   end

endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq import ata_strobe_pkg::*; #(
   parameter int DEV_W = 1,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid_i,
   input  logic [DEV_W-1:0] req_dev_i,
   input  logic             req_write_i,
   input  logic             req_tf_i,
   input  logic [TW_W-1:0]  word_i,
   output logic             req_ready_o,
   output logic             done_o,
   output logic             unsup_o,
   output logic             strobe_on_o,
   output logic             dir_write_o
);

   phase_e           st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] act_q, act_d;
   logic [CNT_W-1:0] rec_q, rec_d;
   logic [DEV_W-1:0] dev_q, dev_d;
   logic             wr_q, wr_d;
   logic             tf_q, tf_d;
   logic             accept, same_kind, refuse, last_cyc;
   phase_len_t       lens;

   assign lens      = pick_lens(word_i, req_tf_i);
   assign last_cyc  = (cnt_q == '0);
   assign done_o    = ((st_q == PH_RECOVER) && last_cyc) || (st_q == PH_REJECT);
   assign req_ready_o = (st_q == PH_IDLE) || done_o;
   assign accept    = req_valid_i && req_ready_o;
   assign same_kind = (st_q == PH_RECOVER) && (dev_q == req_dev_i)
                      && (wr_q == req_write_i) && (tf_q == req_tf_i);
   assign refuse    = !req_tf_i && word_i[F_UDMA_BIT];
   assign unsup_o   = (st_q == PH_REJECT);
   assign strobe_on_o = (st_q == PH_ACTIVE);
   assign dir_write_o = wr_q;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      act_d = act_q;
      rec_d = rec_q;
      dev_d = dev_q;
      wr_d  = wr_q;
      tf_d  = tf_q;
      if (accept) begin
         act_d = CNT_W'(lens.act);
         rec_d = CNT_W'(lens.rec);
         dev_d = req_dev_i;
         wr_d  = req_write_i;
         tf_d  = req_tf_i;
         if (refuse) begin
            st_d  = PH_REJECT;
            cnt_d = '0;
         end else if (same_kind) begin
            st_d  = PH_ACTIVE;
            cnt_d = CNT_W'(lens.act);
         end else begin
            st_d  = PH_SETUP;
            cnt_d = CNT_W'(lens.setup);
         end
      end else begin
         unique case (st_q)
            PH_SETUP: begin
               if (last_cyc) begin
                  st_d  = PH_ACTIVE;
                  cnt_d = act_q;
               end else
                  cnt_d = cnt_q - 1'b1;
            end
            PH_ACTIVE: begin
               if (last_cyc) begin
                  st_d  = PH_RECOVER;
                  cnt_d = rec_q;
               end else
                  cnt_d = cnt_q - 1'b1;
            end
            PH_RECOVER: begin
               if (last_cyc)
                  st_d = PH_IDLE;
               else
                  cnt_d = cnt_q - 1'b1;
            end
            PH_REJECT: st_d = PH_IDLE;
            default:   st_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= PH_IDLE;
         cnt_q <= '0;
         act_q <= '0;
         rec_q <= '0;
         dev_q <= '0;
         wr_q  <= 1'b0;
         tf_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         act_q <= act_d;
         rec_q <= rec_d;
         dev_q <= dev_d;
         wr_q  <= wr_d;
         tf_q  <= tf_d;
      end
   end

   // R5
   b2b_direct_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && same_kind && !refuse) |=> strobe_on_o);

   // R4
   setup_first_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && !same_kind && !refuse) |=> (!strobe_on_o && !done_o));

   // R6
   idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && !req_valid_i) |=> (req_ready_o && !done_o));

   // R10
   len_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !accept |=> $stable({act_q, rec_q}));

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen import ata_strobe_pkg::*; #(
   parameter int              NUM_DEV  = 2,
   parameter int              CNT_W    = 4,
   parameter logic [TW_W-1:0] TW_RESET = '0,
   localparam int             DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tw_wr_en,
   input  logic [DEV_W-1:0] tw_wr_dev,
   input  logic [TW_W-1:0]  tw_wr_data,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [DEV_W-1:0] req_dev,
   input  logic             req_write,
   input  logic             req_taskfile,
   output logic             dior_n,
   output logic             diow_n,
   output logic             xfer_done,
   output logic             unsup_mode
);

   if (NUM_DEV < 1) begin : g_bad_dev
      $error("ata_strobe_gen: NUM_DEV must be at least 1");
   end
   if (CNT_W < LEN_W) begin : g_bad_cnt
      $error("ata_strobe_gen: CNT_W too narrow for the phase fields");
   end

   logic [TW_W-1:0] sel_word;
   logic            strobe_on, dir_write;

   ata_tword_bank #(
      .NUM_DEV  (NUM_DEV),
      .TW_RESET (TW_RESET)
   ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en_i   (tw_wr_en),
      .wr_dev_i  (tw_wr_dev),
      .wr_data_i (tw_wr_data),
      .rd_dev_i  (req_dev),
      .rd_word_o (sel_word)
   );

   ata_phase_seq #(
      .DEV_W (DEV_W),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .req_valid_i (req_valid),
      .req_dev_i   (req_dev),
      .req_write_i (req_write),
      .req_tf_i    (req_taskfile),
      .word_i      (sel_word),
      .req_ready_o (req_ready),
      .done_o      (xfer_done),
      .unsup_o     (unsup_mode),
      .strobe_on_o (strobe_on),
      .dir_write_o (dir_write)
   );

   assign dior_n = ~(strobe_on & ~dir_write);
   assign diow_n = ~(strobe_on &  dir_write);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!dior_n && !diow_n));

   // R9
   unsup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      unsup_mode |-> (dior_n && diow_n && xfer_done));

   // R6
   no_done_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (!dior_n || !diow_n) |-> !xfer_done);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (dior_n && diow_n && !xfer_done && !unsup_mode && req_ready));

endmodule

// File: tb/tb_ata_strobe_gen.sv
module tb_ata_strobe_gen;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_we;
   logic [0:0]  cfg_dev;
   logic [31:0] cfg_data;
   logic        req_valid;
   logic [0:0]  req_dev;
   logic        req_write;
   logic        req_tf;
   logic        req_ready, dior_n, diow_n, done, unsup;

   always #5 clk = ~clk;

   ata_strobe_gen #(.NUM_DEV(2)) dut (
      .clk          (clk),
      .rst          (rst),
      .tw_wr_en     (cfg_we),
      .tw_wr_dev    (cfg_dev),
      .tw_wr_data   (cfg_data),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_dev      (req_dev),
      .req_write    (req_write),
      .req_taskfile (req_tf),
      .dior_n       (dior_n),
      .diow_n       (diow_n),
      .xfer_done    (done),
      .unsup_mode   (unsup)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   int    cycles = 0;
   string cur_req = "R1";

   // behavioural reference: phase 0 idle, 1 setup, 2 strobe, 3 recovery, 4 refused
   int          ph = 0, rem = 0, m_act = 0, m_rec = 0;
   logic        m_wr = 1'b0, m_tf = 1'b0, m_dev = 1'b0;
   logic [31:0] mword [2];
   bit          started = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         ph = 0; rem = 0; mword[0] = '0; mword[1] = '0; started = 1'b1;
      end else begin
         bit          dn, acc, same;
         logic [31:0] w;
         dn  = (ph == 3 && rem == 1) || ph == 4;
         acc = req_valid && (ph == 0 || dn);
         if (acc) begin
            w     = mword[req_dev];
            same  = (ph == 3) && m_dev == req_dev && m_wr == req_write && m_tf == req_tf;
            m_act = req_tf ? int'(w[15:12]) + 1 : int'(w[7:4]) + 1;
            m_rec = req_tf ? int'(w[11:8])  + 1 : int'(w[3:0]) + 1;
            m_dev = req_dev; m_wr = req_write; m_tf = req_tf;
            if (!req_tf && w[28]) ph = 4;
            else if (same) begin ph = 2; rem = m_act; end
            else begin
               ph  = 1;
               rem = req_tf ? int'(w[24:22]) + 1 : int'(w[21:19]) + 1;
            end
         end else begin
            case (ph)
               1: if (rem == 1) begin ph = 2; rem = m_act; end else rem--;
               2: if (rem == 1) begin ph = 3; rem = m_rec; end else rem--;
               3: if (rem == 1) ph = 0; else rem--;
               4: ph = 0;
               default: ph = 0;
            endcase
         end
         if (cfg_we) mword[cfg_dev] = cfg_data;
      end
   end

   task automatic check(string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         logic e_done;
         e_done = (ph == 3 && rem == 1) || ph == 4;
         check("dior_n (R7)", dior_n, !(ph == 2 && !m_wr));
         check("diow_n (R7)", diow_n, !(ph == 2 && m_wr));
         check("done (R6)",   done,   e_done);
         check("unsup (R9)",  unsup,  ph == 4);
         check("ready (R6)",  req_ready, ph == 0 || e_done);
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual=%0d expected<150000 cycles", cycles);
         finish_run();
      end
   end

   task automatic tw_write(int dev, logic [31:0] val);
      cfg_we = 1'b1; cfg_dev = dev[0]; cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic issue(int dev, logic wr, logic tf);
      req_valid = 1'b1; req_dev = dev[0]; req_write = wr; req_tf = tf;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic go_idle();
      req_valid = 1'b0;
      while (!(req_ready && !done)) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      rst = 1'b1; cfg_we = 1'b0; cfg_dev = '0; cfg_data = '0;
      req_valid = 1'b0; req_dev = '0; req_write = 1'b0; req_tf = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: zero words after reset, one clock per phase
      cur_req = "R1";
      issue(0, 1'b0, 1'b0);
      go_idle();

      // R2 / R4: data read on device 0
      tw_write(0, 32'h0110_3152);
      tw_write(1, 32'h0068_0670);
      cur_req = "R2";
      issue(0, 1'b0, 1'b0);
      go_idle();
      // R3: task-file write
      cur_req = "R3";
      issue(0, 1'b1, 1'b1);
      go_idle();
      // R8: device 1 uses its own word
      cur_req = "R8";
      issue(1, 1'b0, 1'b0);
      go_idle();
      issue(1, 1'b1, 1'b1);
      go_idle();

      // R5: back-to-back same kind, then R4 change of direction / class / device
      cur_req = "R5";
      issue(0, 1'b1, 1'b0);
      issue(0, 1'b1, 1'b0);
      issue(0, 1'b1, 1'b0);
      cur_req = "R4";
      issue(0, 1'b0, 1'b0);
      issue(0, 1'b0, 1'b1);
      issue(1, 1'b0, 1'b1);
      go_idle();

      // R9: Ultra DMA selected; data refused, task-file unaffected
      cur_req = "R9";
      tw_write(1, 32'h1068_0670);
      issue(1, 1'b0, 1'b0);
      issue(1, 1'b1, 1'b0);
      issue(1, 1'b1, 1'b1);
      go_idle();

      // R10: word rewritten mid-access
      cur_req = "R10";
      tw_write(0, 32'h01F8_FFFF);
      issue(0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      tw_write(0, 32'h0000_0021);
      go_idle();
      issue(0, 1'b0, 1'b0);
      go_idle();

      // R1: reset during an active strobe
      cur_req = "R1";
      tw_write(0, 32'h0000_00F0);
      issue(0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      go_idle();

      // random mix of words and requests
      cur_req = "R6";
      for (int i = 0; i < 400; i++) begin
         if ($urandom % 6 == 0) begin
            logic [31:0] w;
            w = $urandom;
            w[28] = ($urandom % 4 == 0);
            tw_write(int'($urandom % 2), w);
         end
         issue(int'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
         if ($urandom % 3 == 0) go_idle();
      end
      go_idle();
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule